// File: doc/BRIEF.md
# Asymmetric Dual-Issue Dispatch

This block sits between an in-order fetch buffer and two execution pipes of unequal depth. Every cycle the buffer presents its two oldest decoded instructions, slot 0 (older) and slot 1 (younger). The block sorts each into one of two classes. The integer class goes to the five-stage integer pipe. The floating-point-compute class goes to the seven-stage floating-point pipe. The block then decides in the same cycle whether both instructions leave, only the older one leaves, or neither does.

Both instructions leave together only under all of these conditions: the pair holds exactly one instruction of each class, the younger does not depend on the older through a register, and both pipes can accept. Issue is strictly in program order. Each pipe gets a strobe and a select bit that says which slot it takes. The fetch buffer gets the number of instructions consumed, so it can advance by that amount. The decision is combinational. The clock and the synchronous active-low reset only time the embedded checks.

Top module: `dual_dispatch`

## Requirements
- R1: The kind code is 3 bits: 0 integer ALU, 1 branch, 2 integer load/store, 3 floating-point load/store (all integer class), 4 FP add, 5 FP subtract, 6 FP fused multiply-add, 7 FP convert (all FP-compute class). An integer-class instruction that issues raises `int_go`. An FP-compute instruction that issues raises `fp_go`.
- R2: An independent pair of one integer-class and one FP-compute instruction, with both pipes free, issues both in one cycle with `consumed`=2. Each `*_pick` is 0 when its pipe takes slot 0, 1 when it takes slot 1, and 0 whenever its `*_go` is low.
- R3: Two instructions of the same class never issue together. Only the older issues and `consumed`=1.
- R4: The younger instruction issues only in a cycle where the older one issues.
- R5: If the older writes a register (`dst_en`=1) that the younger reads through any enabled source field, only the older issues.
- R6: If both write the same register, only the older issues.
- R7: Register tag 0 is the integer zero register. An older write to tag 0 creates no dependency.
- R8: `int_stall` blocks every integer-class issue and `fp_stall` blocks every FP-compute issue. A stall on one pipe does not block an instruction bound for the other.
- R9: `consumed` always equals the number of asserted issue strobes, and is never more than 2.
- R10: Invalid slots and disabled source fields are ignored. A lone valid older instruction issues alone when its pipe is free. A valid younger instruction with an invalid older one does not issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Synchronous active-low reset |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_kind | input | 3 | Older instruction kind code |
| s0_dst_en | input | 1 | Older instruction writes a register |
| s0_dst | input | REG_W | Older destination tag |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_kind | input | 3 | Younger instruction kind code |
| s1_src_en | input | NUM_SRC | Per-field source enables, younger |
| s1_src | input | NUM_SRC*REG_W | Younger source tags, field i at bits i*REG_W |
| s1_dst_en | input | 1 | Younger instruction writes a register |
| s1_dst | input | REG_W | Younger destination tag |
| int_stall | input | 1 | Integer pipe cannot accept |
| fp_stall | input | 1 | FP pipe cannot accept |
| int_go | output | 1 | Integer pipe takes an instruction |
| int_pick | output | 1 | Slot taken by the integer pipe |
| fp_go | output | 1 | FP pipe takes an instruction |
| fp_pick | output | 1 | Slot taken by the FP pipe |
| consumed | output | 2 | Instructions consumed this cycle |

## Verification
The bench targets these cases:
- Class boundaries. A floating-point load/store paired with an FP compute must co-issue. A design that classed it by its register file would serialize the pair or send it down the wrong pipe.
- Dependencies. The bench sets a raw dependency on the third source field only, and a write-after-write on pipes of different depth. A design that checked only the first sources, or skipped output dependencies, would wrongly report `consumed`=2.
- The zero register. A dependency through tag 0 must not split the pair.
- Stalls. A stalled older instruction must hold back a younger one bound for the free pipe. An out-of-order design would issue the younger alone.
- Invalid older slot. A younger instruction behind an invalid older slot must not issue. A design that checks only the younger's own validity would issue it.

// File: rtl/dd_pkg.sv
// Shared definitions for the dual-issue dispatch block.
// Assumes a 3-bit kind code supplied by the decoder.
package dd_pkg;

    typedef enum logic [2:0] {
        K_ALU    = 3'd0,
        K_BRANCH = 3'd1,
        K_IMEM   = 3'd2,
        K_FMEM   = 3'd3,
        K_FADD   = 3'd4,
        K_FSUB   = 3'd5,
        K_FMADD  = 3'd6,
        K_FCVT   = 3'd7
    } kind_e;

    // Returns 1 for the floating-point-compute class, 0 for the integer class.
    function automatic logic is_fp_compute(input logic [2:0] kind);
        logic fp;
        case (kind_e'(kind))
            K_ALU, K_BRANCH, K_IMEM, K_FMEM: fp = 1'b0;
            K_FADD, K_FSUB, K_FMADD, K_FCVT: fp = 1'b1;
            default:                         fp = 1'b0;
        endcase
        return fp;
    endfunction

endpackage

// File: rtl/dd_classify.sv
// Classifies one slot and reports whether its target pipe can take it now.
// Assumes the stall inputs are valid for the current cycle.
module dd_classify (
    input  logic       valid,
    input  logic [2:0] kind,
    input  logic       int_stall,
    input  logic       fp_stall,
    output logic       is_fp,
    output logic       ready
);
    import dd_pkg::*;

    // Class decode and pipe availability for this slot.
    always_comb begin
        is_fp = is_fp_compute(kind);
        ready = valid && (is_fp ? !fp_stall : !int_stall);
    end
endmodule

// File: rtl/dd_hazard.sv
// Detects register dependencies of the younger slot on the older slot.
// Assumes tag 0 names the hard-wired integer zero register.
module dd_hazard #(
    parameter int REG_W   = 6,
    parameter int NUM_SRC = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     old_dst_en,
    input  logic [REG_W-1:0]         old_dst,
    input  logic [NUM_SRC-1:0]       yng_src_en,
    input  logic [NUM_SRC*REG_W-1:0] yng_src,
    input  logic                     yng_dst_en,
    input  logic [REG_W-1:0]         yng_dst,
    output logic                     raw,
    output logic                     waw
);
    localparam logic [REG_W-1:0] ZERO_TAG = '0;

    logic             old_live;
    logic [NUM_SRC-1:0] src_hit;

    // An older write only matters if it targets a real register.
    always_comb old_live = old_dst_en && (old_dst != ZERO_TAG);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        // Compare one enabled source field against the older destination.
        always_comb src_hit[i] = yng_src_en[i] && (yng_src[i*REG_W +: REG_W] == old_dst);
    end

    // Combine per-field hits and the output-dependency compare.
    always_comb begin
        raw = old_live && (|src_hit);
        waw = old_live && yng_dst_en && (yng_dst == old_dst);
    end

    // R7
    zero_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (old_dst == ZERO_TAG) |-> (!raw && !waw));
    // R10
    dis_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (yng_src_en == '0 && !yng_dst_en) |-> (!raw && !waw));
endmodule

// File: rtl/dd_steer.sv
// Makes the in-order issue decision and routes slots to the two pipes.
// Assumes slot 0 is older than slot 1.
module dd_steer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rdy0,
    input  logic       fp0,
    input  logic       vld1,
    input  logic       rdy1,
    input  logic       fp1,
    input  logic       raw,
    input  logic       waw,
    input  logic       int_stall,
    input  logic       fp_stall,
    output logic       int_go,
    output logic       int_pick,
    output logic       fp_go,
    output logic       fp_pick,
    output logic [1:0] consumed
);
    logic iss0, iss1;

    // Older goes when its pipe is free; younger only alongside it.
    always_comb begin
        iss0 = rdy0;
        iss1 = iss0 && rdy1 && (fp0 != fp1) && !raw && !waw;
    end

    // Route the issued slots to the pipes and count them.
    always_comb begin
        int_go   = (iss0 && !fp0) || (iss1 && !fp1);
        int_pick = iss1 && !fp1;
        fp_go    = (iss0 && fp0) || (iss1 && fp1);
        fp_pick  = iss1 && fp1;
        consumed = {1'b0, iss0} + {1'b0, iss1};
    end

    // R9
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consumed == ({1'b0, int_go} + {1'b0, fp_go}));
    // R8
    int_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_stall |-> !int_go);
    // R8
    fp_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fp_stall |-> !fp_go);
    // R4
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy0) |-> (consumed == 2'd0));
    // R5
    raw_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw |-> (consumed != 2'd2));
    // R6
    waw_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        waw |-> (consumed != 2'd2));
    // R3
    same_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld1 && fp0 == fp1) |-> (consumed != 2'd2));
endmodule

// File: rtl/dual_dispatch.sv
// Top of the asymmetric dual-issue dispatch: classifies both slots,
// checks the pair for dependencies and issues in program order.
// Assumes the fetch buffer advances by `consumed` each cycle.
module dual_dispatch #(
    parameter int REG_W   = 6,
    parameter int NUM_SRC = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s0_valid,
    input  logic [2:0]               s0_kind,
    input  logic                     s0_dst_en,
    input  logic [REG_W-1:0]         s0_dst,
    input  logic                     s1_valid,
    input  logic [2:0]               s1_kind,
    input  logic [NUM_SRC-1:0]       s1_src_en,
    input  logic [NUM_SRC*REG_W-1:0] s1_src,
    input  logic                     s1_dst_en,
    input  logic [REG_W-1:0]         s1_dst,
    input  logic                     int_stall,
    input  logic                     fp_stall,
    output logic                     int_go,
    output logic                     int_pick,
    output logic                     fp_go,
    output logic                     fp_pick,
    output logic [1:0]               consumed
);
    localparam int NSLOT = 2;

    logic [NSLOT-1:0]      slot_vld;
    logic [NSLOT-1:0][2:0] slot_kind;
    logic [NSLOT-1:0]      slot_fp;
    logic [NSLOT-1:0]      slot_rdy;
    logic                  raw, waw;

    // Gather per-slot fields into arrays for the classifier loop.
    always_comb begin
        slot_vld  = {s1_valid, s0_valid};
        slot_kind = {s1_kind, s0_kind};
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        dd_classify u_cls (
            .valid     (slot_vld[s]),
            .kind      (slot_kind[s]),
            .int_stall (int_stall),
            .fp_stall  (fp_stall),
            .is_fp     (slot_fp[s]),
            .ready     (slot_rdy[s])
        );
    end

    dd_hazard #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_haz (
        .clk        (clk),
        .rst_n      (rst_n),
        .old_dst_en (s0_dst_en),
        .old_dst    (s0_dst),
        .yng_src_en (s1_src_en),
        .yng_src    (s1_src),
        .yng_dst_en (s1_dst_en),
        .yng_dst    (s1_dst),
        .raw        (raw),
        .waw        (waw)
    );

    dd_steer u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rdy0      (slot_rdy[0]),
        .fp0       (slot_fp[0]),
        .vld1      (slot_vld[1]),
        .rdy1      (slot_rdy[1]),
        .fp1       (slot_fp[1]),
        .raw       (raw),
        .waw       (waw),
        .int_stall (int_stall),
        .fp_stall  (fp_stall),
        .int_go    (int_go),
        .int_pick  (int_pick),
        .fp_go     (fp_go),
        .fp_pick   (fp_pick),
        .consumed  (consumed)
    );

    // R10
    younger_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s0_valid) |-> (!int_go && !fp_go));
    // R1
    fmem_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && s0_kind == 3'd3 && !int_stall) |-> (int_go && !int_pick));
endmodule

// File: tb/dual_dispatch_test.sv
module dual_dispatch_test;
    localparam int CLK_PERIOD = 10;
    localparam int REG_W = 6;
    localparam int NUM_SRC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s0_valid, s0_dst_en, s1_valid, s1_dst_en, int_stall, fp_stall;
    logic [2:0] s0_kind, s1_kind;
    logic [REG_W-1:0] s0_dst, s1_dst;
    logic [NUM_SRC-1:0] s1_src_en;
    logic [NUM_SRC*REG_W-1:0] s1_src;
    logic int_go, int_pick, fp_go, fp_pick;
    logic [1:0] consumed;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_dispatch #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) uut (
        .clk(clk), .rst_n(rst_n),
        .s0_valid(s0_valid), .s0_kind(s0_kind), .s0_dst_en(s0_dst_en), .s0_dst(s0_dst),
        .s1_valid(s1_valid), .s1_kind(s1_kind), .s1_src_en(s1_src_en), .s1_src(s1_src),
        .s1_dst_en(s1_dst_en), .s1_dst(s1_dst),
        .int_stall(int_stall), .fp_stall(fp_stall),
        .int_go(int_go), .int_pick(int_pick), .fp_go(fp_go), .fp_pick(fp_pick),
        .consumed(consumed)
    );

    task automatic clear_all();
        s0_valid = 0; s0_kind = 0; s0_dst_en = 0; s0_dst = 0;
        s1_valid = 0; s1_kind = 0; s1_src_en = 0; s1_src = 0;
        s1_dst_en = 0; s1_dst = 0; int_stall = 0; fp_stall = 0;
    endtask

    task automatic pair(input logic [2:0] k0, input logic d0en, input logic [REG_W-1:0] d0,
                        input logic [2:0] k1, input logic [NUM_SRC-1:0] sen,
                        input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
                        input logic [REG_W-1:0] c, input logic d1en,
                        input logic [REG_W-1:0] d1);
        @(negedge clk);
        clear_all();
        s0_valid = 1; s0_kind = k0; s0_dst_en = d0en; s0_dst = d0;
        s1_valid = 1; s1_kind = k1; s1_src_en = sen; s1_src = {c, b, a};
        s1_dst_en = d1en; s1_dst = d1;
    endtask

    task automatic expect_out(input string req, input logic eig, input logic eip,
                              input logic efg, input logic efp, input logic [1:0] ec);
        #1;
        checks++;
        if ({int_go, int_pick, fp_go, fp_pick, consumed} != {eig, eip, efg, efp, ec}) begin
            errors++;
            $display("FAIL %s: got int_go=%0b int_pick=%0b fp_go=%0b fp_pick=%0b consumed=%0d, expected %0b %0b %0b %0b %0d",
                     req, int_go, int_pick, fp_go, fp_pick, consumed, eig, eip, efg, efp, ec);
        end
    endtask

    task automatic t_idle();
        @(negedge clk); clear_all();
        expect_out("R10 idle", 0, 0, 0, 0, 2'd0);
    endtask

    task automatic t_coissue();
        pair(3'd0, 1, 6'd5, 3'd4, 3'b011, 6'd33, 6'd34, 6'd0, 1, 6'd35);
        expect_out("R2 alu+fadd", 1, 0, 1, 1, 2'd2);
        pair(3'd6, 1, 6'd40, 3'd3, 3'b001, 6'd7, 6'd0, 6'd0, 1, 6'd41);
        expect_out("R1 fmadd+fmem", 1, 1, 1, 0, 2'd2);
        pair(3'd1, 0, 6'd0, 3'd7, 3'b001, 6'd36, 6'd0, 6'd0, 1, 6'd37);
        expect_out("R1 branch+fcvt", 1, 0, 1, 1, 2'd2);
    endtask

    task automatic t_same_class();
        pair(3'd0, 1, 6'd5, 3'd2, 3'b001, 6'd6, 6'd0, 6'd0, 1, 6'd8);
        expect_out("R3 alu+imem", 1, 0, 0, 0, 2'd1);
        pair(3'd5, 1, 6'd40, 3'd7, 3'b001, 6'd41, 6'd0, 6'd0, 1, 6'd42);
        expect_out("R3 fsub+fcvt", 0, 0, 1, 0, 2'd1);
    endtask

    task automatic t_deps();
        pair(3'd3, 1, 6'd33, 3'd6, 3'b111, 6'd34, 6'd35, 6'd33, 1, 6'd36);
        expect_out("R5 raw third field", 1, 0, 0, 0, 2'd1);
        pair(3'd3, 1, 6'd33, 3'd6, 3'b011, 6'd34, 6'd35, 6'd33, 1, 6'd36);
        expect_out("R10 disabled field", 1, 0, 1, 1, 2'd2);
        pair(3'd7, 1, 6'd40, 3'd3, 3'b001, 6'd9, 6'd0, 6'd0, 1, 6'd40);
        expect_out("R6 waw", 0, 0, 1, 0, 2'd1);
        pair(3'd0, 1, 6'd0, 3'd4, 3'b001, 6'd0, 6'd0, 6'd0, 1, 6'd0);
        expect_out("R7 zero reg", 1, 0, 1, 1, 2'd2);
    endtask

    task automatic t_stalls();
        pair(3'd0, 1, 6'd5, 3'd4, 3'b001, 6'd33, 6'd0, 6'd0, 1, 6'd35);
        int_stall = 1;
        expect_out("R4 older stalled", 0, 0, 0, 0, 2'd0);
        int_stall = 0; fp_stall = 1;
        expect_out("R8 fp stalled", 1, 0, 0, 0, 2'd1);
        pair(3'd4, 1, 6'd40, 3'd2, 3'b001, 6'd5, 6'd0, 6'd0, 1, 6'd6);
        fp_stall = 1;
        expect_out("R4 fp older stalled", 0, 0, 0, 0, 2'd0);
        fp_stall = 0; int_stall = 1;
        expect_out("R8 int stalled", 0, 0, 1, 0, 2'd1);
    endtask

    task automatic t_lone();
        @(negedge clk); clear_all();
        s0_valid = 1; s0_kind = 3'd2;
        expect_out("R10 lone older", 1, 0, 0, 0, 2'd1);
        @(negedge clk); clear_all();
        s1_valid = 1; s1_kind = 3'd4;
        expect_out("R10 lone younger", 0, 0, 0, 0, 2'd0);
        @(negedge clk); clear_all();
        s0_valid = 1; s0_kind = 3'd7; s1_kind = 3'd0;
        expect_out("R9 fp lone", 0, 0, 1, 0, 2'd1);
    endtask

    initial begin
        clear_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_idle();
        t_coissue();
        t_same_class();
        t_deps();
        t_stalls();
        t_lone();
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: got %0d cycles, expected under 5000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end
endmodule